// File: doc/BRIEF.md
# Byte-Select External Memory Write Controller

This block runs a single write transaction to a word-wide external memory that can write one byte of a 16-bit word at a time. Address and data share one 16-bit multiplexed bus. A start pulse captures a byte pointer, an 8-bit data value and the address-width setting. The block then sequences an address phase, a turnaround clock, a two-clock write strobe and a release clock. It flags completion with a one-clock done pulse.

The byte is always copied onto both halves of the bus. The target lane is picked by the pointer's lowest bit. That bit is driven on a byte-address line for memories that take a byte address, and is also decoded into active-low upper and lower byte enables for memories that use lane enables. Only the high write strobe is used. The low write strobe and the read output enable stay inactive.

Top module: `bsel_wr_ctrl`

## Requirements
- R1: After reset, and whenever idle, ale_o=0, wrh_n_o=1, wrl_n_o=1, oe_n_o=1, ad_oe_o=0, ad_o=0, busy_o=0, done_o=0, ba0_o=0, ub_n_o=1, lb_n_o=1 and addr_hi_o=0.
- R2: In the first clock after an accepted start, ale_o=1, ad_oe_o=1, busy_o=1 and ad_o carries pointer bits [16:1]. ale_o is high for exactly that one clock.
- R3: In the clock after the address phase, ale_o=0, wrh_n_o=1, and ad_o still holds the address.
- R4: In the next two clocks, wrh_n_o=0 and ad_o = {data, data}, with the byte mirrored on bits [15:8] and [7:0].
- R5: wrl_n_o and oe_n_o stay 1 in every clock, including throughout a transaction.
- R6: While busy, ba0_o equals pointer bit 0. When that bit is 0, lb_n_o=0 and ub_n_o=1. When it is 1, ub_n_o=0 and lb_n_o=1.
- R7: While busy, addr_hi_o equals pointer bits [20:17] if wide_i was 1 at the accepted start, and 0 if wide_i was 0.
- R8: After the strobe there is one release clock with wrh_n_o=1, ad_oe_o=1, busy_o=1 and done_o=0. In the following clock done_o=1, busy_o=0 and ad_oe_o=0. done_o lasts one clock.
- R9: A start that arrives while busy is ignored. The pointer, data and width are captured only on an accepted start, so input changes during a transaction do not alter its outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Begin a write when idle |
| ptr_i | input | 21 | Byte pointer; bit 0 selects the lane, bits [20:1] are the word address |
| data_i | input | 8 | Byte to write |
| wide_i | input | 1 | 1 = 20-bit word address, 0 = 16-bit |
| ad_o | output | 16 | Multiplexed address/data bus value |
| ad_oe_o | output | 1 | Bus drive enable (1 = drive) |
| ale_o | output | 1 | Address latch enable |
| addr_hi_o | output | 4 | Upper word address bits |
| wrh_n_o | output | 1 | High write strobe, active low |
| wrl_n_o | output | 1 | Low write strobe, always inactive |
| oe_n_o | output | 1 | Memory output enable, always inactive |
| ba0_o | output | 1 | Byte address line |
| ub_n_o | output | 1 | Upper byte enable, active low |
| lb_n_o | output | 1 | Lower byte enable, active low |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-clock completion pulse |

## Verification
Random pointers and data are run with both width settings. Even and odd pointers show whether the lane decode and the byte-address line follow bit 0. Wide and narrow runs with nonzero upper pointer bits show whether the upper address lines are gated correctly. Directed cases use all-zero and all-one pointers and data, a bus pattern whose halves differ to expose a broken mirror, and a start asserted mid-transaction while the inputs are scrambled. The last case separates correct capture-on-accept from logic that passes its inputs straight through.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_TURN = 3'd2,
    ST_WR1  = 3'd3,
    ST_WR2  = 3'd4,
    ST_REL  = 3'd5
  } phase_t;
endpackage

// File: rtl/bsel_rst_sync.sv
module bsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bsel_seq.sv
module bsel_seq
  import bsel_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  output logic   accept_o,
  output phase_t phase_o,
  output logic   done_o
);
  phase_t phase_q, phase_d;
  logic   done_q, done_d;

  assign accept_o = start_i && (phase_q == ST_IDLE);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      ST_IDLE: if (accept_o) phase_d = ST_ADDR;
      ST_ADDR: phase_d = ST_TURN;
      ST_TURN: phase_d = ST_WR1;
      ST_WR1:  phase_d = ST_WR2;
      ST_WR2:  phase_d = ST_REL;
      ST_REL:  phase_d = ST_IDLE;
      default: phase_d = ST_IDLE;
    endcase
    done_d = (phase_q == ST_REL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  assign phase_o = phase_q;
  assign done_o  = done_q;
endmodule

// File: rtl/bsel_lane.sv
module bsel_lane
  import bsel_pkg::*;
#(
  parameter int AD_W  = 16,
  parameter int PTR_W = 21,
  localparam int DATA_W = AD_W / 2,
  localparam int HI_W   = PTR_W - 1 - AD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  phase_t            phase_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wide_i,
  output logic [AD_W-1:0]   ad_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic              wrh_n_o,
  output logic              ba0_o,
  output logic              ub_n_o,
  output logic              lb_n_o
);
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] data_q;
  logic              wide_q;
  logic              busy, strobe, addr_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      data_q <= '0;
      wide_q <= 1'b0;
    end else if (accept_i) begin
      ptr_q  <= ptr_i;
      data_q <= data_i;
      wide_q <= wide_i;
    end
  end

  always_comb begin
    busy    = (phase_i != ST_IDLE);
    strobe  = (phase_i == ST_WR1) || (phase_i == ST_WR2);
    addr_ph = (phase_i == ST_ADDR) || (phase_i == ST_TURN);
    ale_o   = (phase_i == ST_ADDR);
    wrh_n_o = !strobe;
    ad_oe_o = busy;
    if (addr_ph)   ad_o = ptr_q[AD_W:1];
    else if (busy) ad_o = {data_q, data_q};
    else           ad_o = '0;
    addr_hi_o = (busy && wide_q) ? ptr_q[PTR_W-1:AD_W+1] : '0;
    ba0_o     = busy && ptr_q[0];
    ub_n_o    = !(busy && ptr_q[0]);
    lb_n_o    = !(busy && !ptr_q[0]);
  end
endmodule

// File: rtl/bsel_wr_ctrl.sv
module bsel_wr_ctrl
  import bsel_pkg::*;
#(
  parameter int AD_W  = 16,
  parameter int PTR_W = 21,
  localparam int DATA_W = AD_W / 2,
  localparam int HI_W   = PTR_W - 1 - AD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wide_i,
  output logic [AD_W-1:0]   ad_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic              wrh_n_o,
  output logic              wrl_n_o,
  output logic              oe_n_o,
  output logic              ba0_o,
  output logic              ub_n_o,
  output logic              lb_n_o,
  output logic              busy_o,
  output logic              done_o
);
  logic   rst_sync_n;
  logic   accept;
  phase_t phase;

  bsel_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  bsel_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_i),
    .accept_o(accept), .phase_o(phase), .done_o(done_o)
  );

  bsel_lane #(.AD_W(AD_W), .PTR_W(PTR_W)) u_lane (
    .clk(clk), .rst_n(rst_sync_n), .accept_i(accept), .phase_i(phase),
    .ptr_i(ptr_i), .data_i(data_i), .wide_i(wide_i),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ale_o(ale_o), .addr_hi_o(addr_hi_o),
    .wrh_n_o(wrh_n_o), .ba0_o(ba0_o), .ub_n_o(ub_n_o), .lb_n_o(lb_n_o)
  );

  assign busy_o  = (phase != ST_IDLE);
  assign wrl_n_o = 1'b1;
  assign oe_n_o  = 1'b1;
endmodule

// File: rtl/bsel_wr_chk.sv
module bsel_wr_chk #(
  parameter int AD_W  = 16,
  parameter int PTR_W = 21,
  localparam int DATA_W = AD_W / 2,
  localparam int HI_W   = PTR_W - 1 - AD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [PTR_W-1:0]  ptr_i,
  input logic [DATA_W-1:0] data_i,
  input logic              wide_i,
  input logic [AD_W-1:0]   ad_o,
  input logic              ad_oe_o,
  input logic              ale_o,
  input logic [HI_W-1:0]   addr_hi_o,
  input logic              wrh_n_o,
  input logic              wrl_n_o,
  input logic              oe_n_o,
  input logic              ba0_o,
  input logic              ub_n_o,
  input logic              lb_n_o,
  input logic              busy_o,
  input logic              done_o
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!ale_o && wrh_n_o && !ad_oe_o && ub_n_o && lb_n_o && addr_hi_o == '0));
  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> !ale_o);
  p_turn_no_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale_o) |-> (wrh_n_o && busy_o));
  p_strobe_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wrh_n_o) |=> (!wrh_n_o ##1 wrh_n_o));
  p_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wrh_n_o |-> (ad_o[AD_W-1:DATA_W] == ad_o[DATA_W-1:0]));
  p_unused_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrl_n_o && oe_n_o);
  p_lane_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ((ub_n_o ^ lb_n_o) && (ba0_o == lb_n_o)));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o) && !ad_oe_o));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind bsel_wr_ctrl bsel_wr_chk #(.AD_W(AD_W), .PTR_W(PTR_W)) u_chk (.*);

// File: tb/bsel_wr_ctrl_bench.sv
module bsel_wr_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [20:0] ptr_i = '0;
  logic [7:0]  data_i = '0;
  logic        wide_i = 1'b0;
  logic [15:0] ad_o;
  logic        ad_oe_o, ale_o, wrh_n_o, wrl_n_o, oe_n_o;
  logic [3:0]  addr_hi_o;
  logic        ba0_o, ub_n_o, lb_n_o, busy_o, done_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsel_wr_ctrl u_bsel_wr_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ptr_i(ptr_i),
    .data_i(data_i), .wide_i(wide_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .ale_o(ale_o), .addr_hi_o(addr_hi_o), .wrh_n_o(wrh_n_o),
    .wrl_n_o(wrl_n_o), .oe_n_o(oe_n_o), .ba0_o(ba0_o), .ub_n_o(ub_n_o),
    .lb_n_o(lb_n_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_hi(input logic [20:0] p, input logic w);
    return w ? p[20:17] : 4'h0;
  endfunction

  function automatic logic [2:0] exp_lane(input logic [20:0] p);
    // {ba0, ub_n, lb_n}
    return p[0] ? 3'b101 : 3'b010;
  endfunction

  task automatic check_idle(input string tag);
    check(!ale_o && wrh_n_o && !ad_oe_o && ad_o == 16'h0 && !busy_o,
          {"R1 idle bus ", tag}, {ale_o, wrh_n_o, ad_oe_o, busy_o, ad_o}, 32'h4_0000);
    check({ba0_o, ub_n_o, lb_n_o} == 3'b011 && addr_hi_o == 4'h0,
          {"R1 idle lanes ", tag}, {addr_hi_o, ba0_o, ub_n_o, lb_n_o}, 32'h03);
    check(wrl_n_o && oe_n_o, {"R5 idle ", tag}, {wrl_n_o, oe_n_o}, 32'h3);
  endtask

  task automatic check_busy_common(input logic [20:0] p, input logic w, input string ph);
    check({ba0_o, ub_n_o, lb_n_o} == exp_lane(p), {"R6 lane ", ph},
          {ba0_o, ub_n_o, lb_n_o}, exp_lane(p));
    check(addr_hi_o == exp_hi(p, w), {"R7 upper addr ", ph}, addr_hi_o, exp_hi(p, w));
    check(wrl_n_o && oe_n_o, {"R5 busy ", ph}, {wrl_n_o, oe_n_o}, 32'h3);
    check(busy_o && ad_oe_o, {"R8 busy/oe ", ph}, {busy_o, ad_oe_o}, 32'h3);
  endtask

  task automatic run_txn(input logic [20:0] p, input logic [7:0] d, input logic w,
                         input bit poke);
    @(negedge clk);
    start_i = 1'b1; ptr_i = p; data_i = d; wide_i = w;
    @(negedge clk);
    start_i = 1'b0; ptr_i = $urandom; data_i = $urandom; wide_i = $urandom;
    check(ale_o == 1'b1 && ad_o == p[16:1] && wrh_n_o, "R2 address phase",
          {ale_o, wrh_n_o, ad_o}, {2'b11, p[16:1]});
    check_busy_common(p, w, "addr");
    @(negedge clk);
    if (poke) begin
      start_i = 1'b1; ptr_i = ~p; data_i = ~d; wide_i = ~w;
    end
    check(!ale_o && wrh_n_o && ad_o == p[16:1], "R3 turnaround",
          {ale_o, wrh_n_o, ad_o}, {2'b01, p[16:1]});
    check_busy_common(p, w, "turn");
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      check(!wrh_n_o && ad_o == {d, d} && !ale_o, "R4 data strobe",
            {ale_o, wrh_n_o, ad_o}, {2'b00, d, d});
      check_busy_common(p, w, poke ? "R9 data after poke" : "data");
    end
    @(negedge clk);
    check(wrh_n_o && !done_o && !ale_o, "R8 release", {wrh_n_o, done_o}, 32'h2);
    check_busy_common(p, w, "release");
    @(negedge clk);
    check(done_o && !busy_o && !ad_oe_o, "R8 done", {done_o, busy_o, ad_oe_o}, 32'h4);
    @(negedge clk);
    check(!done_o && !busy_o, poke ? "R9 ignored start" : "R8 done single",
          {done_o, busy_o}, 32'h0);
    check_idle("after");
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("reset R1");
    // directed corners
    run_txn(21'h000000, 8'h00, 1'b0, 1'b0);
    run_txn(21'h1FFFFF, 8'hFF, 1'b1, 1'b0);
    run_txn(21'h1FFFFF, 8'hA5, 1'b0, 1'b0);
    run_txn(21'h0ABCDE, 8'h3C, 1'b1, 1'b1);
    run_txn(21'h155555, 8'h81, 1'b1, 1'b1);
    // random stimulus
    for (int i = 0; i < 60; i++) begin
      run_txn(21'($urandom), 8'($urandom), 1'($urandom), ($urandom % 4) == 0);
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule